// File: doc/BRIEF.md
# Transfer Descriptor Token Update Engine

This block holds the 32-bit token word of one USB host transfer descriptor and rewrites it after every bus transaction the host completes. Software writes a fresh token through a load port. The host engine then reports each transaction through a result strobe. The strobe carries an outcome code and the number of bytes that were actually moved. The block keeps the remaining byte count, data toggle, page index and retry counter up to date. It decides when the descriptor retires or halts and raises a one-cycle interrupt request when that happens.

The token fields sit at fixed bit positions because the rest of the host decodes them. The toggle is bit 31. The remaining byte count is bits 30:16. The interrupt-on-complete flag is bit 15. The page index is bits 14:12. The 2-bit retry counter is bits 11:10. The PID code is bits 9:8. Bits 7:0 are passed through unchanged. A separate 12-bit offset, loaded with the token, tracks the position inside the current 4 KB page. The block also presents the token byte that matches the PID code, so the bus side can send it.

Top module: `td_token_engine`

## Requirements
- R1: A load (`load_valid`) copies `load_token` to `token_q` and `load_off` into the page offset. It sets `active` to 1 and clears `halted` and `err_flags`. This holds whatever state came before, including a halt.
- R2: A success strobe (`res_code` 0) reduces bits 30:16 by the moved byte count. The moved count is `res_bytes` limited to the remaining count. The strobe also inverts bit 31.
- R3: When bits 30:16 are zero, a success strobe is a zero-length transaction. It leaves the count at zero and clears `active`.
- R4: A success that leaves the count at zero clears `active`. So does an IN transaction (PID code 01) that moves fewer than `max_pkt` bytes. In both cases `irq` pulses for exactly one cycle if bit 15 is set.
- R5: A transaction error (`res_code` 1) with a retry count of 2 or 3 reduces the count by one and keeps the descriptor active. From a count of 1 it sets the count to 0 and halts. A halt clears `active`, sets `halted` and sets `err_flags[0]`. `irq` pulses when `err_irq_en` is high.
- R6: A data buffer error (`res_code` 2) leaves the whole token unchanged and the descriptor active.
- R7: A stall (`res_code` 3) or a babble (`res_code` 4) halts at once without touching the retry count. A stall sets `err_flags[1]` and a babble sets `err_flags[2]`. `irq` pulses when `err_irq_en` is high.
- R8: A retry count of zero is never changed. Transaction errors then neither count nor halt, and a success never restores it.
- R9: A success with a non-zero retry count restores the count to 3, but only when `hs_ep` or `async_sched` is high and the PID code is OUT (00) or IN (01). In every other case the count is kept.
- R10: `pid_byte` is 0xE1 for PID code 00, 0x69 for 01, 0x2D for 10 and 0x00 for 11. Any strobe on an active descriptor with code 11 halts it, sets `err_flags[0]` and leaves the token unchanged.
- R11: On success the page index in bits 14:12 advances by one for every 4 KB boundary that offset plus moved bytes crosses. The index saturates at 4, and the offset wraps modulo 4096.
- R12: Result strobes have no effect while `active` is low, including while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Software load of a new token |
| load_token | input | 32 | Token word to load |
| load_off | input | 12 | Starting offset in the first page |
| res_valid | input | 1 | Transaction result strobe |
| res_code | input | 3 | 0 success, 1 transaction error, 2 buffer error, 3 stall, 4 babble |
| res_bytes | input | 15 | Bytes moved by the transaction |
| hs_ep | input | 1 | Endpoint is high-speed |
| async_sched | input | 1 | Descriptor is in the asynchronous schedule |
| max_pkt | input | 11 | Maximum packet length of the endpoint |
| err_irq_en | input | 1 | Enables interrupt on error halt |
| token_q | output | 32 | Current token word |
| active | output | 1 | Descriptor is active |
| halted | output | 1 | Descriptor halted on an error |
| err_flags | output | 3 | Halt cause: [0] transaction error, [1] stall, [2] babble |
| pid_byte | output | 8 | Token byte for the PID code |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Every registered result appears on the clock edge that samples the load or result strobe. The bench therefore drives inputs on falling edges and reads all outputs at the next falling edge, one cycle after each stimulus. `irq` is read again one cycle later to confirm that it is a single-cycle pulse. `pid_byte` is combinational from the token and is read after the load edge. Checks that a strobe is ignored send the strobe and then read `token_q`, `active` and `halted` at that same next falling edge.

// File: rtl/td_token_pkg.sv
package td_token_pkg;
    localparam int TOTAL_W = 15;
    localparam int PAGE_W  = 3;
    localparam int CERR_W  = 2;
    localparam int OFF_W   = 12;
    localparam int MPL_W   = 11;
    localparam int MAX_PAGE = 4;
    localparam logic [CERR_W-1:0] CERR_FULL = '1;

    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_XERR   = 3'd1,
        RES_BUFERR = 3'd2,
        RES_STALL  = 3'd3,
        RES_BABBLE = 3'd4
    } res_e;

    typedef enum logic [1:0] {
        PID_OUT   = 2'b00,
        PID_IN    = 2'b01,
        PID_SETUP = 2'b10,
        PID_RSVD  = 2'b11
    } pid_e;

    typedef struct packed {
        logic               tgl;
        logic [TOTAL_W-1:0] total;
        logic               ioc;
        logic [PAGE_W-1:0]  page;
        logic [CERR_W-1:0]  cerr;
        logic [1:0]         pid;
        logic [7:0]         low;
    } token_t;

    typedef struct packed {
        token_t             tok;
        logic [OFF_W-1:0]   off;
        logic               active;
        logic               halted;
        logic [2:0]         flags;
        logic               irq;
    } state_t;
endpackage

// File: rtl/td_pid_map.sv
module td_pid_map (
    input  logic [1:0] pid_code,
    output logic [7:0] pid_byte
);
    always_comb begin
        case (pid_code)
            2'b00:   pid_byte = 8'hE1;
            2'b01:   pid_byte = 8'h69;
            2'b10:   pid_byte = 8'h2D;
            default: pid_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/td_cerr_unit.sv
module td_cerr_unit
    import td_token_pkg::*;
(
    input  logic [CERR_W-1:0] cerr_in,
    input  logic [2:0]        code,
    input  logic              restore_ok,
    output logic [CERR_W-1:0] cerr_out,
    output logic              err_halt
);
    always_comb begin
        cerr_out = cerr_in;
        err_halt = 1'b0;
        case (code)
            RES_OK: begin
                if (cerr_in != '0 && restore_ok) cerr_out = CERR_FULL;
            end
            RES_XERR: begin
                if (cerr_in != '0) begin
                    cerr_out = cerr_in - 1'b1;
                    err_halt = (cerr_in == CERR_W'(1));
                end
            end
            RES_STALL, RES_BABBLE: err_halt = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/td_page_adv.sv
module td_page_adv
    import td_token_pkg::*;
(
    input  logic [PAGE_W-1:0]  page_in,
    input  logic [OFF_W-1:0]   off_in,
    input  logic [TOTAL_W-1:0] moved,
    output logic [PAGE_W-1:0]  page_out,
    output logic [OFF_W-1:0]   off_out
);
    localparam int SUM_W = TOTAL_W + 1;
    localparam int CARRY_W = SUM_W - OFF_W;

    logic [SUM_W-1:0]   sum;
    logic [CARRY_W:0]   page_sum;

    always_comb begin
        sum      = SUM_W'(off_in) + SUM_W'(moved);
        off_out  = sum[OFF_W-1:0];
        page_sum = (CARRY_W+1)'(page_in) + (CARRY_W+1)'(sum[SUM_W-1:OFF_W]);
        if (page_sum > (CARRY_W+1)'(MAX_PAGE)) page_out = PAGE_W'(MAX_PAGE);
        else                                   page_out = page_sum[PAGE_W-1:0];
    end
endmodule

// File: rtl/td_token_engine.sv
module td_token_engine
    import td_token_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_valid,
    input  logic [31:0]        load_token,
    input  logic [OFF_W-1:0]   load_off,
    input  logic               res_valid,
    input  logic [2:0]         res_code,
    input  logic [TOTAL_W-1:0] res_bytes,
    input  logic               hs_ep,
    input  logic               async_sched,
    input  logic [MPL_W-1:0]   max_pkt,
    input  logic               err_irq_en,
    output logic [31:0]        token_q,
    output logic               active,
    output logic               halted,
    output logic [2:0]         err_flags,
    output logic [7:0]         pid_byte,
    output logic               irq
);
    state_t st_d, st_q;

    logic [TOTAL_W-1:0] moved;
    logic [TOTAL_W-1:0] total_left;
    logic [CERR_W-1:0]  cerr_n;
    logic               err_halt;
    logic               restore_ok;
    logic [PAGE_W-1:0]  page_n;
    logic [OFF_W-1:0]   off_n;
    logic               short_in;

    assign moved      = (res_bytes > st_q.tok.total) ? st_q.tok.total : res_bytes;
    assign total_left = st_q.tok.total - moved;
    assign restore_ok = (hs_ep || async_sched) &&
                        (st_q.tok.pid == PID_OUT || st_q.tok.pid == PID_IN);
    assign short_in   = (st_q.tok.pid == PID_IN) && (res_bytes < TOTAL_W'(max_pkt));

    td_cerr_unit u_cerr (
        .cerr_in   (st_q.tok.cerr),
        .code      (res_code),
        .restore_ok(restore_ok),
        .cerr_out  (cerr_n),
        .err_halt  (err_halt)
    );

    td_page_adv u_page (
        .page_in (st_q.tok.page),
        .off_in  (st_q.off),
        .moved   (moved),
        .page_out(page_n),
        .off_out (off_n)
    );

    td_pid_map u_pid (
        .pid_code(st_q.tok.pid),
        .pid_byte(pid_byte)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load_valid) begin
            st_d.tok    = token_t'(load_token);
            st_d.off    = load_off;
            st_d.active = 1'b1;
            st_d.halted = 1'b0;
            st_d.flags  = '0;
        end else if (res_valid && st_q.active) begin
            if (st_q.tok.pid == PID_RSVD) begin
                st_d.active   = 1'b0;
                st_d.halted   = 1'b1;
                st_d.flags[0] = 1'b1;
                st_d.irq      = err_irq_en;
            end else begin
                case (res_code)
                    RES_OK: begin
                        st_d.tok.total = total_left;
                        st_d.tok.tgl   = ~st_q.tok.tgl;
                        st_d.tok.cerr  = cerr_n;
                        st_d.tok.page  = page_n;
                        st_d.off       = off_n;
                        if (total_left == '0 || short_in) begin
                            st_d.active = 1'b0;
                            st_d.irq    = st_q.tok.ioc;
                        end
                    end
                    RES_XERR: begin
                        st_d.tok.cerr = cerr_n;
                        if (err_halt) begin
                            st_d.active   = 1'b0;
                            st_d.halted   = 1'b1;
                            st_d.flags[0] = 1'b1;
                            st_d.irq      = err_irq_en;
                        end
                    end
                    RES_STALL, RES_BABBLE: begin
                        st_d.active = 1'b0;
                        st_d.halted = 1'b1;
                        if (res_code == RES_STALL) st_d.flags[1] = 1'b1;
                        else                       st_d.flags[2] = 1'b1;
                        st_d.irq    = err_irq_en;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign token_q   = st_q.tok;
    assign active    = st_q.active;
    assign halted    = st_q.halted;
    assign err_flags = st_q.flags;
    assign irq       = st_q.irq;

    a_r7_halt_not_active: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !active);

    a_r12_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load_valid) |=> $stable(token_q));

    a_r2_total_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load_valid) |=> (token_q[30:16] <= $past(token_q[30:16])));

    a_r8_zero_cerr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (token_q[11:10] == 2'b00 && !load_valid) |=> (token_q[11:10] == 2'b00));

    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r4_irq_retired: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !active);
endmodule

// File: tb/sim_td_token_engine.sv
module sim_td_token_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_token = '0;
    logic [11:0] load_off = '0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_code = '0;
    logic [14:0] res_bytes = '0;
    logic        hs_ep = 1'b0;
    logic        async_sched = 1'b0;
    logic [10:0] max_pkt = 11'd512;
    logic        err_irq_en = 1'b1;
    logic [31:0] token_q;
    logic        active, halted, irq;
    logic [2:0]  err_flags;
    logic [7:0]  pid_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    td_token_engine u0 (.*);

    typedef struct packed {
        logic [31:0] tok;
        logic [11:0] off;
        logic [2:0]  code;
        logic [14:0] bytes;
        logic        hs;
        logic        as;
        logic [31:0] etok;
        logic        eact;
        logic        ehalt;
        logic [2:0]  eflags;
        logic        eirq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{32'h04008800, 12'h000, 3'd0, 15'h0200, 1'b0, 1'b0, 32'h82008800, 1'b1, 1'b0, 3'b000, 1'b0}, // R2 no restore
        '{32'h04008800, 12'h000, 3'd0, 15'h0200, 1'b1, 1'b0, 32'h82008C00, 1'b1, 1'b0, 3'b000, 1'b0}, // R9 hs restore
        '{32'h02008400, 12'h000, 3'd0, 15'h0200, 1'b0, 1'b1, 32'h80008C00, 1'b0, 1'b0, 3'b000, 1'b1}, // R4 count zero
        '{32'h00000D00, 12'h000, 3'd0, 15'h0000, 1'b0, 1'b0, 32'h80000D00, 1'b0, 1'b0, 3'b000, 1'b0}, // R3 zero length
        '{32'h10008900, 12'h000, 3'd0, 15'h0040, 1'b0, 1'b0, 32'h8FC08900, 1'b0, 1'b0, 3'b000, 1'b1}, // R4 short IN
        '{32'h10000000, 12'hF00, 3'd0, 15'h0200, 1'b1, 1'b0, 32'h8E001000, 1'b1, 1'b0, 3'b000, 1'b0}, // R11 page, R8
        '{32'h01000C00, 12'h000, 3'd1, 15'h0000, 1'b0, 1'b0, 32'h01000800, 1'b1, 1'b0, 3'b000, 1'b0}, // R5 3->2
        '{32'h01000400, 12'h000, 3'd1, 15'h0000, 1'b0, 1'b0, 32'h01000000, 1'b0, 1'b1, 3'b001, 1'b1}, // R5 1->halt
        '{32'h01000000, 12'h000, 3'd1, 15'h0000, 1'b0, 1'b0, 32'h01000000, 1'b1, 1'b0, 3'b000, 1'b0}, // R8 unlimited
        '{32'h01000C00, 12'h000, 3'd2, 15'h0000, 1'b0, 1'b0, 32'h01000C00, 1'b1, 1'b0, 3'b000, 1'b0}, // R6 buffer
        '{32'h01000800, 12'h000, 3'd3, 15'h0000, 1'b0, 1'b0, 32'h01000800, 1'b0, 1'b1, 3'b010, 1'b1}, // R7 stall
        '{32'h01000800, 12'h000, 3'd4, 15'h0000, 1'b0, 1'b0, 32'h01000800, 1'b0, 1'b1, 3'b100, 1'b1}, // R7 babble
        '{32'h01000B00, 12'h000, 3'd0, 15'h0010, 1'b0, 1'b0, 32'h01000B00, 1'b0, 1'b1, 3'b001, 1'b1}, // R10 code 11
        '{32'h00080A00, 12'h000, 3'd0, 15'h0008, 1'b1, 1'b0, 32'h80000A00, 1'b0, 1'b0, 3'b000, 1'b0}, // R9 SETUP kept
        '{32'h10004000, 12'hFFF, 3'd0, 15'h0100, 1'b0, 1'b0, 32'h8F004000, 1'b1, 1'b0, 3'b000, 1'b0}, // R11 saturate
        '{32'h20000000, 12'h800, 3'd0, 15'h1C00, 1'b0, 1'b0, 32'h84002000, 1'b1, 1'b0, 3'b000, 1'b0}  // R11 two pages
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] t, input logic [11:0] o);
        @(negedge clk);
        load_valid = 1'b1; load_token = t; load_off = o;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic do_res(input logic [2:0] c, input logic [14:0] b);
        res_valid = 1'b1; res_code = c; res_bytes = b;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(token_q == 0 && !active && !halted && !irq && err_flags == 0, "R1 reset",
            {token_q[31:4], active, halted, irq, 1'b0}, 32'h0);
        // R12 strobe while idle after reset
        do_res(3'd0, 15'h10);
        chk(token_q == 0 && !active, "R12 idle strobe", token_q, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            hs_ep = v.hs; async_sched = v.as;
            do_load(v.tok, v.off);
            chk(token_q == v.tok && active && !halted, "R1 load", token_q, v.tok);
            do_res(v.code, v.bytes);
            chk(token_q == v.etok, $sformatf("R2-vector%0d token", i), token_q, v.etok);
            chk({active, halted, err_flags, irq} == {v.eact, v.ehalt, v.eflags, v.eirq},
                $sformatf("R4-vector%0d status", i),
                {26'd0, active, halted, err_flags, irq}, {26'd0, v.eact, v.ehalt, v.eflags, v.eirq});
            @(negedge clk);
            chk(!irq, "R4 irq single cycle", {31'd0, irq}, 32'd0);
        end
        hs_ep = 1'b0; async_sched = 1'b0;

        // R12 strobe after a halt is ignored; R1 load clears the halt
        do_load(32'h01000800, 12'h0);
        do_res(3'd3, 15'h0);
        do_res(3'd0, 15'h0100);
        chk(token_q == 32'h01000800 && halted && !active, "R12 halted strobe", token_q, 32'h01000800);
        do_load(32'h01000800, 12'h0);
        chk(!halted && active && err_flags == 0, "R1 load clears halt",
            {29'd0, halted, active, 1'b0}, 32'h2);

        // R10 PID byte mapping
        do_load(32'h00000000, 12'h0);
        chk(pid_byte == 8'hE1, "R10 OUT byte", {24'd0, pid_byte}, 32'hE1);
        do_load(32'h00000100, 12'h0);
        chk(pid_byte == 8'h69, "R10 IN byte", {24'd0, pid_byte}, 32'h69);
        do_load(32'h00000200, 12'h0);
        chk(pid_byte == 8'h2D, "R10 SETUP byte", {24'd0, pid_byte}, 32'h2D);

        // R7 stall with error interrupt disabled gives no irq
        err_irq_en = 1'b0;
        do_load(32'h01000800, 12'h0);
        do_res(3'd3, 15'h0);
        chk(halted && !irq, "R7 stall irq disabled", {31'd0, irq}, 32'd0);
        err_irq_en = 1'b1;

        // R5 count down across three errors to a halt
        do_load(32'h01000C00, 12'h0);
        do_res(3'd1, 15'h0);
        do_res(3'd1, 15'h0);
        chk(token_q[11:10] == 2'd1 && active, "R5 two errors", {30'd0, token_q[11:10]}, 32'd1);
        do_res(3'd1, 15'h0);
        chk(halted && err_flags == 3'b001 && irq, "R5 third error halts",
            {29'd0, err_flags}, 32'd1);

        // R2 bytes limited to the remaining count
        do_load(32'h00108000, 12'h0);
        do_res(3'd0, 15'h0100);
        chk(token_q == 32'h80008000 && !active && irq, "R2 clamp moved", token_q, 32'h80008000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule